// File: doc/BRIEF.md
# Branch Mispredict Squash Controller

This block decides which in-flight instructions to discard when a branch in a 3-wide, in-order, six-stage pipeline resolves as mispredicted. The stages run fetch, decode, issue, two execute stages (X0 and X1) and writeback. A branch outcome is known only at the end of X1. At that point every instruction younger than the branch has to be turned into a bubble. The one exception is an optional single delay-slot instruction, which must be spared.

The controller is purely combinational. It reads the valid bits of each slot in F, D, I, X0 and X1, the slot that holds the branch inside its X1 group, a mispredict strobe and a delay-slot enable. It returns one kill mask per stage and the number of instructions squashed. The surrounding pipeline clears valid bits with these masks on the same clock edge, so squashed slots are bubbles in the following cycle.

The delay-slot instruction is not assumed to sit in a fixed stage. Because the pipeline is in order, the controller spares the first valid instruction younger than the branch. That instruction may be in the branch's own group or in any earlier stage. If no younger instruction is valid, the delay slot has not been fetched yet and nothing is spared. There is no stream data at this block's edge, so all pins are plain control and status signals.

Top module: `squash_ctrl`

## Requirements
- R1: While `mispredict` is 0, every kill mask and `kill_cnt` are 0, whatever the other inputs are.
- R2: Program order follows slot index, where slot 0 is the oldest of its group, and `br_slot` is the binary slot index of the branch in X1. X1 slots at or below `br_slot` are never killed. Valid X1 slots above it are killed unless one of them is the spared delay slot.
- R3: With `delay_en` 0, every valid slot in F, D, I and X0 is killed. An invalid slot is never killed in any stage.
- R4: With `delay_en` 1, the first valid instruction younger than the branch is spared. The search order is the X1 slots above `br_slot`, then X0, I, D and F, and within each stage from slot 0 upward. All other younger valid instructions are killed.
- R5: With `delay_en` 1 and no valid instruction younger than the branch, nothing is spared and nothing is killed. If the delay slot is absent while other younger instructions exist, every younger valid instruction is killed.
- R6: `kill_cnt` equals the number of set kill bits across all stages. On a pipeline with no bubbles the count is 14 for a branch in slot 0 with no delay slot, 13 for slot 0 with a delay slot, 12 for slot 2 with no delay slot and 11 for slot 2 with a delay slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mispredict | input | 1 | Branch in X1 resolved against its prediction this cycle |
| br_slot | input | SLOT_W (2) | Slot of the mispredicting branch in the X1 group, 0 is oldest |
| delay_en | input | 1 | Spare one delay-slot instruction after the branch |
| vld_f | input | WIDTH (3) | Per-slot valid bits of the fetch stage |
| vld_d | input | WIDTH (3) | Per-slot valid bits of the decode stage |
| vld_i | input | WIDTH (3) | Per-slot valid bits of the issue stage |
| vld_x0 | input | WIDTH (3) | Per-slot valid bits of execute stage X0 |
| vld_x1 | input | WIDTH (3) | Per-slot valid bits of execute stage X1 |
| kill_f | output | WIDTH (3) | Slots of F to clear |
| kill_d | output | WIDTH (3) | Slots of D to clear |
| kill_i | output | WIDTH (3) | Slots of I to clear |
| kill_x0 | output | WIDTH (3) | Slots of X0 to clear |
| kill_x1 | output | WIDTH (3) | Slots of X1 to clear |
| kill_cnt | output | CNT_W (4) | Number of instructions squashed |

## Verification
The assertions assume two things about the inputs. A raised `mispredict` names a `br_slot` inside the group width, and that X1 slot holds a valid instruction, because only a real branch can resolve. Every directed scenario drives `br_slot` onto a valid X1 slot and keeps it below the width. Scenarios with the strobe low are still free to leave X1 empty. The scenarios cover the following cases:
- The delay slot sitting next to the branch in X1.
- The delay slot sitting in X0 or in I.
- The delay slot absent from the pipeline.
- Bubble patterns that move the delay slot and change the count.

// File: rtl/squash_pkg.sv
package squash_pkg;

  // Stage order by age: X1 holds the oldest work, F the youngest.
  typedef enum logic [2:0] {
    STG_X1 = 3'd0,
    STG_X0 = 3'd1,
    STG_I  = 3'd2,
    STG_D  = 3'd3,
    STG_F  = 3'd4
  } stage_e;

  localparam int NUM_STAGES = 5;

endpackage

// File: rtl/sq_oldest_pick.sv
// Chooses the lowest set bit of an age-ordered request vector.
module sq_oldest_pick #(
  parameter int N = 15
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign pick[i]   = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  always_comb begin
    if (!$isunknown(req)) begin
      AST_PICK_ONEHOT: assert ($onehot0(pick))
        else $error("pick has more than one bit set"); // R4
      AST_PICK_COVERS: assert ((req == '0) == (pick == '0))
        else $error("pick empty while requests pending"); // R5
    end
  end

endmodule

// File: rtl/sq_kill_gen.sv
// Forms the squash vector from the younger-valid set and the spared slot.
module sq_kill_gen #(
  parameter int N = 15
) (
  input  logic         mispredict,
  input  logic         delay_en,
  input  logic [N-1:0] younger_vld,
  input  logic [N-1:0] spare,
  output logic [N-1:0] kill
);

  logic [N-1:0] keep;

  assign keep = delay_en ? spare : '0;

  always_comb begin
    kill = '0;
    if (mispredict) begin
      kill = younger_vld & ~keep;
    end
  end

  always_comb begin
    if (!$isunknown({mispredict, delay_en, younger_vld, spare})) begin
      AST_KILL_YOUNG_ONLY: assert ((kill & ~younger_vld) == '0)
        else $error("kill outside younger valid set"); // R3
    end
  end

endmodule

// File: rtl/sq_popcount.sv
// Counts set bits of the squash vector.
module sq_popcount #(
  parameter int N     = 15,
  parameter int CNT_W = 4
) (
  input  logic [N-1:0]     bits,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CNT_W'(bits[i]);
    end
  end

endmodule

// File: rtl/squash_ctrl.sv
module squash_ctrl
  import squash_pkg::*;
#(
  parameter int WIDTH  = 3,
  parameter int SLOT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  parameter int CNT_W  = $clog2(NUM_STAGES * WIDTH + 1)
) (
  input  logic              mispredict,
  input  logic [SLOT_W-1:0] br_slot,
  input  logic              delay_en,
  input  logic [WIDTH-1:0]  vld_f,
  input  logic [WIDTH-1:0]  vld_d,
  input  logic [WIDTH-1:0]  vld_i,
  input  logic [WIDTH-1:0]  vld_x0,
  input  logic [WIDTH-1:0]  vld_x1,
  output logic [WIDTH-1:0]  kill_f,
  output logic [WIDTH-1:0]  kill_d,
  output logic [WIDTH-1:0]  kill_i,
  output logic [WIDTH-1:0]  kill_x0,
  output logic [WIDTH-1:0]  kill_x1,
  output logic [CNT_W-1:0]  kill_cnt
);

  localparam int TOTAL = NUM_STAGES * WIDTH;

  // Age-ordered flat view: bit 0 is X1 slot 0 (oldest), top bit is F last slot.
  logic [TOTAL-1:0] vld_all;
  logic [TOTAL-1:0] younger;
  logic [TOTAL-1:0] younger_vld;
  logic [TOTAL-1:0] spare;
  logic [TOTAL-1:0] kill_all;

  assign vld_all = {vld_f, vld_d, vld_i, vld_x0, vld_x1};

  always_comb begin
    for (int k = 0; k < TOTAL; k++) begin
      younger[k] = (k > int'(br_slot));
    end
  end

  assign younger_vld = vld_all & younger;

  sq_oldest_pick #(.N(TOTAL)) u_pick (
    .req  (younger_vld),
    .pick (spare)
  );

  sq_kill_gen #(.N(TOTAL)) u_kill (
    .mispredict  (mispredict),
    .delay_en    (delay_en),
    .younger_vld (younger_vld),
    .spare       (spare),
    .kill        (kill_all)
  );

  sq_popcount #(.N(TOTAL), .CNT_W(CNT_W)) u_cnt (
    .bits  (kill_all),
    .count (kill_cnt)
  );

  assign kill_x1 = kill_all[int'(STG_X1) * WIDTH +: WIDTH];
  assign kill_x0 = kill_all[int'(STG_X0) * WIDTH +: WIDTH];
  assign kill_i  = kill_all[int'(STG_I)  * WIDTH +: WIDTH];
  assign kill_d  = kill_all[int'(STG_D)  * WIDTH +: WIDTH];
  assign kill_f  = kill_all[int'(STG_F)  * WIDTH +: WIDTH];

  // Port-level checks on the assembled result.
  logic [TOTAL-1:0] kill_ports;
  logic [WIDTH-1:0] older_mask;

  assign kill_ports = {kill_f, kill_d, kill_i, kill_x0, kill_x1};

  always_comb begin
    for (int s = 0; s < WIDTH; s++) begin
      older_mask[s] = (s <= int'(br_slot));
    end
  end

  always_comb begin
    if (!$isunknown({mispredict, br_slot, delay_en, vld_all})) begin
      if (mispredict) begin
        AST_BRANCH_REAL: assert (int'(br_slot) < WIDTH && vld_x1[br_slot])
          else $error("mispredict on empty or out-of-range slot"); // R2
      end
      AST_OLDER_SAFE: assert ((kill_x1 & older_mask) == '0)
        else $error("older X1 slot killed"); // R2
      AST_KILL_SUBSET: assert ((kill_ports & ~vld_all) == '0)
        else $error("bubble slot killed"); // R3
      AST_IDLE_QUIET: assert (mispredict || (kill_ports == '0 && kill_cnt == '0))
        else $error("kill without mispredict"); // R1
      AST_CNT_MATCH: assert (int'(kill_cnt) == $countones(kill_ports))
        else $error("count disagrees with masks"); // R6
      if (mispredict && delay_en && younger_vld != '0) begin
        AST_SPARE_ONE: assert (int'(kill_cnt) == $countones(younger_vld) - 1)
          else $error("delay slot not spared exactly once"); // R4
      end
    end
  end

endmodule

// File: tb/squash_ctrl_bench.sv
`timescale 1ns/1ps
module squash_ctrl_bench;

  localparam int WIDTH = 3;

  logic       clk = 1'b0;
  logic       mispredict;
  logic [1:0] br_slot;
  logic       delay_en;
  logic [2:0] vld_f, vld_d, vld_i, vld_x0, vld_x1;
  logic [2:0] kill_f, kill_d, kill_i, kill_x0, kill_x1;
  logic [3:0] kill_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  squash_ctrl #(.WIDTH(WIDTH)) u_squash_ctrl (
    .mispredict (mispredict),
    .br_slot    (br_slot),
    .delay_en   (delay_en),
    .vld_f      (vld_f),
    .vld_d      (vld_d),
    .vld_i      (vld_i),
    .vld_x0     (vld_x0),
    .vld_x1     (vld_x1),
    .kill_f     (kill_f),
    .kill_d     (kill_d),
    .kill_i     (kill_i),
    .kill_x0    (kill_x0),
    .kill_x1    (kill_x1),
    .kill_cnt   (kill_cnt)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic mp, input logic [1:0] bs, input logic de,
                       input logic [2:0] x1, input logic [2:0] x0,
                       input logic [2:0] i, input logic [2:0] d,
                       input logic [2:0] f);
    @(posedge clk);
    mispredict = mp; br_slot = bs; delay_en = de;
    vld_x1 = x1; vld_x0 = x0; vld_i = i; vld_d = d; vld_f = f;
    @(negedge clk);
  endtask

  task automatic expect_all(input string req, input int ex1, input int ex0,
                            input int ei, input int ed, input int ef,
                            input int ecnt);
    check(req, "kill_x1", int'(kill_x1), ex1);
    check(req, "kill_x0", int'(kill_x0), ex0);
    check(req, "kill_i",  int'(kill_i),  ei);
    check(req, "kill_d",  int'(kill_d),  ed);
    check(req, "kill_f",  int'(kill_f),  ef);
    check(req, "kill_cnt", int'(kill_cnt), ecnt);
  endtask

  task automatic t_idle();
    // R1: full pipeline, no strobe, delay enabled or not
    drive(1'b0, 2'd0, 1'b0, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111);
    expect_all("R1", 0, 0, 0, 0, 0, 0);
    drive(1'b0, 2'd1, 1'b1, 3'b011, 3'b101, 3'b111, 3'b000, 3'b111);
    expect_all("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_scalar();
    // R3: one instruction per stage, four younger squashed
    drive(1'b1, 2'd0, 1'b0, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001);
    expect_all("R3", 0, 1, 1, 1, 1, 4);
  endtask

  task automatic t_full_counts();
    // R6/R2: branch oldest, no delay -> 14
    drive(1'b1, 2'd0, 1'b0, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111);
    expect_all("R6", 6, 7, 7, 7, 7, 14);
    // R6/R4: branch oldest, delay slot is X1 slot 1 -> 13
    drive(1'b1, 2'd0, 1'b1, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111);
    expect_all("R6", 4, 7, 7, 7, 7, 13);
    // R6/R2: branch youngest, no delay -> 12, no X1 kills
    drive(1'b1, 2'd2, 1'b0, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111);
    expect_all("R6", 0, 7, 7, 7, 7, 12);
    // R6/R4: branch youngest, delay slot is X0 slot 0 -> 11
    drive(1'b1, 2'd2, 1'b1, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111);
    expect_all("R6", 0, 6, 7, 7, 7, 11);
  endtask

  task automatic t_middle_slot();
    // R2: branch in slot 1, only slot 2 of X1 killed
    drive(1'b1, 2'd1, 1'b0, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000);
    expect_all("R2", 4, 0, 0, 0, 0, 1);
  endtask

  task automatic t_delay_in_issue();
    // R4: X0 empty, delay slot found in I slot 0
    drive(1'b1, 2'd2, 1'b1, 3'b111, 3'b000, 3'b111, 3'b111, 3'b111);
    expect_all("R4", 0, 0, 6, 7, 7, 8);
  endtask

  task automatic t_delay_gap_in_group();
    // R4: X1 slot 2 bubble, delay slot X1 slot 1, rest all killed
    drive(1'b1, 2'd0, 1'b1, 3'b011, 3'b111, 3'b111, 3'b111, 3'b111);
    expect_all("R4", 0, 7, 7, 7, 7, 12);
  endtask

  task automatic t_bubbles();
    // R3: scattered bubbles, no delay
    drive(1'b1, 2'd0, 1'b0, 3'b111, 3'b010, 3'b000, 3'b101, 3'b011);
    expect_all("R3", 6, 2, 0, 5, 3, 7);
    // R4: same pattern, delay slot is X1 slot 1
    drive(1'b1, 2'd0, 1'b1, 3'b111, 3'b010, 3'b000, 3'b101, 3'b011);
    expect_all("R4", 4, 2, 0, 5, 3, 6);
    // R4: delay slot deep in F slot 1 (only younger valid before F slot 2)
    drive(1'b1, 2'd2, 1'b1, 3'b100, 3'b000, 3'b000, 3'b000, 3'b110);
    expect_all("R4", 0, 0, 0, 0, 4, 1);
  endtask

  task automatic t_delay_absent();
    // R5: nothing younger fetched yet
    drive(1'b1, 2'd2, 1'b1, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000);
    expect_all("R5", 0, 0, 0, 0, 0, 0);
    drive(1'b1, 2'd1, 1'b1, 3'b011, 3'b000, 3'b000, 3'b000, 3'b000);
    expect_all("R5", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    mispredict = 1'b0; br_slot = '0; delay_en = 1'b0;
    vld_f = '0; vld_d = '0; vld_i = '0; vld_x0 = '0; vld_x1 = '0;
    @(negedge clk);
    // R1: quiet state before any stimulus
    expect_all("R1", 0, 0, 0, 0, 0, 0);
    t_idle();
    t_scalar();
    t_full_counts();
    t_middle_slot();
    t_delay_in_issue();
    t_delay_gap_in_group();
    t_bubbles();
    t_delay_absent();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule